// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block collects error and status events from a serial link controller into a 32-bit cause register and qualifies them with a 32-bit enable mask to drive one interrupt line. Most cause bits are sticky: a one-cycle event pulse sets the bit, and the bit stays set until software clears it. Software clears a bit by writing zero to it. Writing one to a cause bit changes nothing, so a handler can clear exactly the bits it has serviced.

Four cause bits mirror the level of four emulated legacy interrupt lines. Separate assert and deassert strobes set and clear them. Software writes do not reach these bits. The mask decides only which set bits may raise the interrupt. It never stops a bit from being recorded. A small register port gives access to both registers. A select input picks the cause register (0) or the mask register (1). Writes take effect at the clock edge. Read data follows the select input combinationally.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, the cause register reads 0x00000000, the mask register reads 0x00000000 and irq_o is 0.
- R2: An event pulse on an ordinary implemented bit sets that cause bit at the next clock edge. The bit then stays set for as long as no clearing write reaches it.
- R3: A write to the cause register (reg_sel_i=0) clears every ordinary bit whose write-data bit is 0. Bits written with 1 keep their value.
- R4: Cause bits 24, 25, 26 and 27 track legacy lines A, B, C and D (leg_assert_i/leg_deassert_i index 0..3). An assert strobe sets the bit and a deassert strobe clears it. When both arrive together, assert wins. Event inputs and software writes do not affect these bits.
- R5: Cause bits 2, 5, 13, 29, 30 and 31 always read 0. Events and writes on these positions are ignored.
- R6: If an event and a clearing write hit the same ordinary bit in the same cycle, the bit ends up set.
- R7: A write to the mask register (reg_sel_i=1) replaces all 32 bits, and the written value reads back unchanged.
- R8: The mask value has no influence on whether a cause bit gets set.
- R9: irq_o is a register holding the OR over all bits of (cause AND mask), taken from the previous cycle. A change in either register therefore shows on irq_o one edge later.
- R10: Reading either register has no side effect. Both registers keep their values for as long as wr_en_i is low and no event or line strobe arrives.
- R11: The ordinary implemented cause bits are 0, 1, 3, 4, 6 to 12, 14 to 23 and 28. The implemented mask is 0x1FFFDFDB, and the ordinary subset is 0x10FFDFDB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | One-cycle event pulses, one per cause bit |
| leg_assert_i | input | 4 | Assert strobes for legacy lines A..D |
| leg_deassert_i | input | 4 | Deassert strobes for legacy lines A..D |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the cause register, 1 selects the mask register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Combined interrupt output |

## Verification
Every cause or mask update is due at the first rising edge after the stimulus. irq_o follows one edge after that, so it lags the register change by one cycle. The bench drives inputs on falling edges and reads registers at the next falling edge. For irq_o it samples twice: once at the first falling edge, where the old level must still hold, and again one cycle later, where the new level must appear. This pins the single register stage on the interrupt path.

// File: rtl/irq_cm_pkg.sv
package irq_cm_pkg;
    localparam int REG_W    = 32;
    localparam int LEG_LO   = 24;
    localparam int LEG_N    = 4;
    localparam logic [REG_W-1:0] IMPL_BITS = 32'h1FFF_DFDB;

    typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/irq_cm_cause.sv
module irq_cm_cause #(
    parameter int W      = 32,
    parameter int LEG_LO = 24,
    parameter int LEG_N  = 4,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     evt_i,
    input  logic [LEG_N-1:0] leg_set_i,
    input  logic [LEG_N-1:0] leg_clr_i,
    input  logic             wr_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     cause_o
);
    localparam logic [W-1:0] LEG_MASK = ((W'(1) << LEG_N) - W'(1)) << LEG_LO;
    localparam logic [W-1:0] ORD_MASK = IMPL & ~LEG_MASK;

    typedef struct packed {
        logic [W-1:0] cause;
    } state_t;

    state_t st_d, st_q;
    logic [W-1:0] nxt;

    // per-bit variant chosen by position: legacy level, sticky event, or reserved
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i] && (i >= LEG_LO) && (i < LEG_LO + LEG_N)) begin : g_leg
            assign nxt[i] = leg_set_i[i-LEG_LO] | (st_q.cause[i] & ~leg_clr_i[i-LEG_LO]);
        end else if (IMPL[i]) begin : g_ord
            // an event in the same cycle overrides the clearing write
            assign nxt[i] = evt_i[i] | (st_q.cause[i] & ~(wr_i & ~wdata_i[i]));
        end else begin : g_rsv
            assign nxt[i] = 1'b0;
        end
    end

    logic unused_inputs;
    assign unused_inputs = ^{evt_i & ~ORD_MASK, wdata_i & ~ORD_MASK};

    always_comb begin
        st_d       = st_q;
        st_d.cause = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;

    // R2: a set ordinary bit stays set unless a clearing write hit it
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(cause_o) & ORD_MASK) & ~($past(wr_i) ? ~$past(wdata_i) : '0)) & ~cause_o) == '0);
    // R6: every ordinary event is recorded, even under a clearing write
    p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt_i) & ORD_MASK) & ~cause_o) == '0);
    // R4: an assert strobe leaves the legacy bit set
    p_leg_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(leg_set_i) & ~cause_o[LEG_LO +: LEG_N]) == '0);
    // R4: a lone deassert strobe leaves the legacy bit clear
    p_leg_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(leg_clr_i & ~leg_set_i) & cause_o[LEG_LO +: LEG_N]) == '0);
endmodule

// File: rtl/irq_cm_mask.sv
module irq_cm_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    // R7: a mask write lands in full
    p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_i) |-> mask_o == $past(wdata_i));
    // R10: without a write the mask holds
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_i) |-> mask_o == $past(mask_o));
endmodule

// File: rtl/irq_cm_reduce.sv
module irq_cm_reduce #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(cause_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
    import irq_cm_pkg::*;
#(
    parameter int W      = REG_W,
    parameter int LEG_BASE = LEG_LO,
    parameter int LEG_CNT  = LEG_N,
    parameter logic [W-1:0] IMPL = IMPL_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       evt_i,
    input  logic [LEG_CNT-1:0] leg_assert_i,
    input  logic [LEG_CNT-1:0] leg_deassert_i,
    input  logic               wr_en_i,
    input  logic               reg_sel_i,
    input  logic [W-1:0]       wdata_i,
    output logic [W-1:0]       rdata_o,
    output logic               irq_o
);
    logic [W-1:0] cause_q;
    logic [W-1:0] mask_q;
    logic         cause_wr;
    logic         mask_wr;

    assign cause_wr = wr_en_i & ~reg_sel_i;
    assign mask_wr  = wr_en_i &  reg_sel_i;

    irq_cm_cause #(.W(W), .LEG_LO(LEG_BASE), .LEG_N(LEG_CNT), .IMPL(IMPL)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .leg_set_i (leg_assert_i),
        .leg_clr_i (leg_deassert_i),
        .wr_i      (cause_wr),
        .wdata_i   (wdata_i),
        .cause_o   (cause_q)
    );

    irq_cm_mask #(.W(W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr),
        .wdata_i (wdata_i),
        .mask_o  (mask_q)
    );

    irq_cm_reduce #(.W(W)) u_reduce (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause_q),
        .mask_i  (mask_q),
        .irq_o   (irq_o)
    );

    assign rdata_o = reg_sel_i ? mask_q : cause_q;

    // R9: with the mask clear for two edges the output must be low
    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0 && $past(mask_q) == '0) |-> !irq_o);
    // R9: with no cause bit on two edges the output must be low
    p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == '0 && $past(cause_q) == '0) |-> !irq_o);
endmodule

// File: tb/irq_cause_unit_tb.sv
module irq_cause_unit_tb_top;
    localparam logic [31:0] IMPL_EXP = 32'h1FFF_DFDB;
    localparam logic [31:0] ORD_EXP  = 32'h10FF_DFDB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic [3:0]  leg_assert_i = '0;
    logic [3:0]  leg_deassert_i = '0;
    logic        wr_en_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_cause_unit dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .leg_assert_i(leg_assert_i), .leg_deassert_i(leg_deassert_i),
        .wr_en_i(wr_en_i), .reg_sel_i(reg_sel_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic rd(input logic s, output logic [31:0] v);
        reg_sel_i = s;
        #1;
        v = rdata_o;
    endtask

    task automatic wr(input logic s, input logic [31:0] d);
        wr_en_i = 1'b1; reg_sel_i = s; wdata_i = d;
        cyc();
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic pulse(input logic [31:0] e);
        evt_i = e;
        cyc();
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); chk("R1 cause", v, 32'h0);
        rd(1'b1, v); chk("R1 mask", v, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        pulse(32'h0080_0101);
        rd(1'b0, v); chk("R2 R11 set", v, 32'h0080_0101);
        cyc(); cyc(); cyc();
        rd(1'b0, v); chk("R2 sticky", v, 32'h0080_0101);
        pulse(32'hFFFF_FFFF);
        rd(1'b0, v); chk("R5 R11 R4 all events", v, ORD_EXP);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(1'b0, ~32'h0000_0100);
        rd(1'b0, v); chk("R3 clear one", v, ORD_EXP & ~32'h0000_0100);
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); chk("R3 ones ignored", v, ORD_EXP & ~32'h0000_0100);
        wr(1'b0, 32'h0);
        rd(1'b0, v); chk("R3 clear all", v, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        pulse(32'h0000_0010);
        evt_i = 32'h0000_0018;
        wr(1'b0, 32'h0);
        evt_i = '0;
        rd(1'b0, v); chk("R6 event beats clear", v, 32'h0000_0018);
        wr(1'b0, 32'h0);
        rd(1'b0, v); chk("R6 then cleared", v, 32'h0);
    endtask

    task automatic t_legacy();
        logic [31:0] v;
        leg_assert_i = 4'b0101; cyc(); leg_assert_i = '0;
        rd(1'b0, v); chk("R4 assert A C", v, 32'h0500_0000);
        wr(1'b0, 32'h0);
        rd(1'b0, v); chk("R4 write ignored", v, 32'h0500_0000);
        leg_deassert_i = 4'b0001; cyc(); leg_deassert_i = '0;
        rd(1'b0, v); chk("R4 deassert A", v, 32'h0400_0000);
        leg_assert_i = 4'b0010; leg_deassert_i = 4'b0110; cyc();
        leg_assert_i = '0; leg_deassert_i = '0;
        rd(1'b0, v); chk("R4 assert wins", v, 32'h0200_0000);
        leg_deassert_i = 4'b1111; cyc(); leg_deassert_i = '0;
        rd(1'b0, v); chk("R4 all released", v, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); chk("R7 mask ones", v, 32'hFFFF_FFFF);
        wr(1'b1, 32'hA5A5_0001);
        rd(1'b1, v); chk("R7 mask pattern", v, 32'hA5A5_0001);
        rd(1'b0, v); cyc(); rd(1'b1, v); cyc(); rd(1'b1, v);
        chk("R10 read no effect", v, 32'hA5A5_0001);
        wr(1'b1, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        pulse(32'h0000_0200);
        rd(1'b0, v); chk("R8 set while masked", v, 32'h0000_0200);
        cyc();
        chk("R9 masked low", {31'h0, irq_o}, 32'h0);
        wr(1'b1, 32'h0000_0200);
        chk("R9 one cycle lag", {31'h0, irq_o}, 32'h0);
        cyc();
        chk("R9 raised", {31'h0, irq_o}, 32'h1);
        wr(1'b0, ~32'h0000_0200);
        chk("R9 still high", {31'h0, irq_o}, 32'h1);
        cyc();
        chk("R9 dropped", {31'h0, irq_o}, 32'h0);
        wr(1'b1, 32'h0800_0000);
        leg_assert_i = 4'b1000; cyc(); leg_assert_i = '0;
        cyc();
        chk("R9 R4 line D irq", {31'h0, irq_o}, 32'h1);
        leg_deassert_i = 4'b1000; cyc(); leg_deassert_i = '0;
        cyc();
        chk("R9 R4 line D off", {31'h0, irq_o}, 32'h0);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_events();
        t_clear();
        t_race();
        t_legacy();
        t_mask();
        t_irq();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule